// File: doc/BRIEF.md
# Exact Clock-Count Program Guard

This block sits next to the serial command front end of a three-wire serial memory. From the moment the front end reports a start bit until chip select drops, it counts every serial clock rising edge, the start bit's own edge included. When chip select falls it compares that count with the exact frame length of the decoded instruction in the active word width. A programming instruction (write, erase, erase-all, write-all) is released to the programming controller only on an exact match. Any other count rejects it. A spurious or missing clock edge shifts the bit stream, and with this check such a frame can never program the wrong cell.

Read and the enable/disable instructions are exempt and raise neither outcome. Inputs are plain control strobes in the system clock domain and the block holds no data, so there is no valid/ready interface. The front end supplies a decoded instruction class that must be stable when chip select falls.

Top module: `clkcnt_write_guard`

## Requirements
- R1: After reset, `allow_o` and `reject_o` are low and no count is in progress.
- R2: A write (kind 3'b100) with `org_x16_i`=0 is allowed only when exactly 18 edges arrive, the start edge included.
- R3: A write with `org_x16_i`=1 is allowed only when exactly 25 edges arrive.
- R4: Erase (3'b101) and erase-all (3'b110) are allowed at exactly 10 edges in byte mode and 9 edges in word mode.
- R5: Write-all (3'b111) needs the same count as write in the same width: 18 in byte mode, 25 in word mode.
- R6: A programming kind whose count differs from its expected length gives a `reject_o` pulse and no `allow_o` pulse.
- R7: Kinds 3'b000 (none), 3'b001 (read) and 3'b010 (enable/disable) produce neither pulse, whatever the count.
- R8: The count saturates at 2**CNT_W-1 and never wraps. A write burst of 18+64 edges is rejected.
- R9: The outcome appears in the system clock cycle after the first cycle in which `cs_i` is sampled low. It lasts exactly one cycle, and `allow_o` and `reject_o` are never high together.
- R10: Edges and start strobes that arrive while `cs_i` is low are ignored. A chip select fall with no start strobe since the previous fall produces no pulse.
- R11: A start strobe while counting restarts the count at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, high during a frame |
| start_i | input | 1 | Start bit detected; coincides with that bit's edge strobe |
| sclk_edge_i | input | 1 | One-cycle strobe per serial clock rising edge |
| op_kind_i | input | 3 | Decoded instruction class; bit 2 marks programming kinds |
| org_x16_i | input | 1 | 1 selects word (x16) width, 0 selects byte (x8) width |
| allow_o | output | 1 | One-cycle pulse: programming request released |
| reject_o | output | 1 | One-cycle pulse: programming request discarded |

## Verification
The only results are the two pulses. Each is due one system clock after the cycle in which chip select is first seen low, because the falling-edge detector and the verdict register both update on that edge. The bench drives inputs on falling clock edges and reads the outcome at the falling edge that follows the chip select drop. It then reads once more a cycle later to confirm that the pulse has ended. The count is checked only through these pulses, with frames built one edge short, exact, and one edge long for each kind and width.

// File: rtl/clkcnt_guard_pkg.sv
package clkcnt_guard_pkg;

  typedef enum logic [2:0] {
    KIND_NONE      = 3'b000,
    KIND_READ      = 3'b001,
    KIND_CTRL      = 3'b010,
    KIND_WRITE     = 3'b100,
    KIND_ERASE     = 3'b101,
    KIND_ERASE_ALL = 3'b110,
    KIND_WRITE_ALL = 3'b111
  } op_kind_e;

  // Programming kinds are marked by the top bit of the class code.
  function automatic logic kind_is_program(input logic [2:0] k);
    return k[2];
  endfunction

  // A kind carries a data field when it stores a value (write, write-all).
  function automatic logic kind_has_data(input logic [2:0] k);
    return (k == KIND_WRITE) || (k == KIND_WRITE_ALL);
  endfunction

endpackage

// File: rtl/cg_fall_detect.sv
module cg_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic fall_o
);
  logic cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  assign fall_o = cs_q & ~cs_i;
endmodule

// File: rtl/cg_edge_counter.sv
module cg_edge_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             start_i,
  input  logic             edge_i,
  input  logic             fall_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (fall_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cs_i && start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CNT_ONE;
    end else if (cs_i && armed_q && edge_i && (cnt_q != CNT_MAX)) begin
      cnt_q   <= cnt_q + CNT_ONE;
    end
  end

  assign armed_o = armed_q;
  assign count_o = cnt_q;

  // R8: a saturated count stays saturated until the frame ends or restarts
  assert_sat_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cnt_q == CNT_MAX && !fall_i && !start_i) |=> (cnt_q == CNT_MAX));

  // R10: a nonzero count only exists inside an armed frame
  assert_cnt_armed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> armed_q);

  // R10: nothing arms while chip select is low
  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !cs_i) |=> !armed_q);

  // R11: a start strobe inside a frame leaves a count of one
  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && start_i && !fall_i) |=> (cnt_q == CNT_ONE));
endmodule

// File: rtl/cg_length_lut.sv
module cg_length_lut
  import clkcnt_guard_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int OPC_W    = 2,
  parameter int ADDR8_W  = 7,
  parameter int ADDR16_W = 6,
  parameter int DATA8_W  = 8,
  parameter int DATA16_W = 16
) (
  input  logic [2:0]       kind_i,
  input  logic             org_x16_i,
  output logic             guarded_o,
  output logic [CNT_W-1:0] need_o
);
  localparam int HDR8   = 1 + OPC_W + ADDR8_W;
  localparam int HDR16  = 1 + OPC_W + ADDR16_W;
  localparam int FULL8  = HDR8 + DATA8_W;
  localparam int FULL16 = HDR16 + DATA16_W;

  logic [CNT_W-1:0] hdr_len, full_len;

  always_comb begin
    hdr_len  = org_x16_i ? CNT_W'(HDR16)  : CNT_W'(HDR8);
    full_len = org_x16_i ? CNT_W'(FULL16) : CNT_W'(FULL8);
    need_o   = kind_has_data(kind_i) ? full_len : hdr_len;
    guarded_o = kind_is_program(kind_i);
  end

  initial begin
    if (FULL16 >= (1 << CNT_W) - 1 || FULL8 >= (1 << CNT_W) - 1)
      $error("counter too narrow for frame length");
  end
endmodule

// File: rtl/cg_verdict.sv
module cg_verdict #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             armed_i,
  input  logic             guarded_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             allow_o,
  output logic             reject_o
);
  logic judge;
  assign judge = fall_i & armed_i & guarded_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      allow_o  <= judge && (count_i == need_i);
      reject_o <= judge && (count_i != need_i);
    end
  end

  // R9: outcomes are exclusive
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(allow_o && reject_o));

  // R9: each outcome lasts a single cycle
  assert_allow_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_o |=> !allow_o);
  assert_reject_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> !reject_o);

  // R7: an outcome follows only a chip select fall on a programming kind
  assert_guard_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_o || reject_o) |-> $past(fall_i && guarded_i));
endmodule

// File: rtl/clkcnt_write_guard.sv
module clkcnt_write_guard #(
  parameter int CNT_W    = 6,
  parameter int OPC_W    = 2,
  parameter int ADDR8_W  = 7,
  parameter int ADDR16_W = 6,
  parameter int DATA8_W  = 8,
  parameter int DATA16_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       start_i,
  input  logic       sclk_edge_i,
  input  logic [2:0] op_kind_i,
  input  logic       org_x16_i,
  output logic       allow_o,
  output logic       reject_o
);
  logic             fall;
  logic             armed;
  logic             guarded;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] need;

  cg_fall_detect u_fall (
    .clk_i (clk_i), .rst_ni (rst_ni), .cs_i (cs_i), .fall_o (fall)
  );

  cg_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .cs_i (cs_i), .start_i (start_i),
    .edge_i (sclk_edge_i), .fall_i (fall), .armed_o (armed), .count_o (count)
  );

  cg_length_lut #(
    .CNT_W(CNT_W), .OPC_W(OPC_W), .ADDR8_W(ADDR8_W), .ADDR16_W(ADDR16_W),
    .DATA8_W(DATA8_W), .DATA16_W(DATA16_W)
  ) u_lut (
    .kind_i (op_kind_i), .org_x16_i (org_x16_i), .guarded_o (guarded), .need_o (need)
  );

  cg_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk_i (clk_i), .rst_ni (rst_ni), .fall_i (fall), .armed_i (armed),
    .guarded_i (guarded), .count_i (count), .need_i (need),
    .allow_o (allow_o), .reject_o (reject_o)
  );

  // R9: an outcome is due only one cycle after chip select is first seen low
  assert_due_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (allow_o || reject_o) |-> ($past(!cs_i) && $past(fall)));
endmodule

// File: tb/clkcnt_write_guard_tb_top.sv
module clkcnt_write_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, start = 1'b0, edge_s = 1'b0, org = 1'b0;
  logic [2:0] kind = 3'b000;
  logic       allow, reject;
  int         checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  clkcnt_write_guard dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cs_i (cs), .start_i (start),
    .sclk_edge_i (edge_s), .op_kind_i (kind), .org_x16_i (org),
    .allow_o (allow), .reject_o (reject)
  );

  // {kind[2:0], org, edges[7:0], exp_allow, exp_reject, req[3:0]}
  localparam int NV = 20;
  localparam logic [17:0] VEC [NV] = '{
    {3'b100, 1'b0, 8'd18, 1'b1, 1'b0, 4'd2},  // R2 exact
    {3'b100, 1'b0, 8'd17, 1'b0, 1'b1, 4'd6},  // R6 short
    {3'b100, 1'b0, 8'd19, 1'b0, 1'b1, 4'd6},  // R6 long
    {3'b100, 1'b1, 8'd25, 1'b1, 1'b0, 4'd3},  // R3 exact
    {3'b100, 1'b1, 8'd24, 1'b0, 1'b1, 4'd6},  // R6
    {3'b100, 1'b1, 8'd18, 1'b0, 1'b1, 4'd3},  // R3 wrong width
    {3'b101, 1'b0, 8'd10, 1'b1, 1'b0, 4'd4},  // R4 erase x8
    {3'b101, 1'b1, 8'd9,  1'b1, 1'b0, 4'd4},  // R4 erase x16
    {3'b101, 1'b1, 8'd10, 1'b0, 1'b1, 4'd4},  // R4
    {3'b110, 1'b0, 8'd10, 1'b1, 1'b0, 4'd4},  // R4 erase-all x8
    {3'b110, 1'b1, 8'd9,  1'b1, 1'b0, 4'd4},  // R4 erase-all x16
    {3'b110, 1'b0, 8'd9,  1'b0, 1'b1, 4'd6},  // R6
    {3'b111, 1'b0, 8'd18, 1'b1, 1'b0, 4'd5},  // R5 x8
    {3'b111, 1'b1, 8'd25, 1'b1, 1'b0, 4'd5},  // R5 x16
    {3'b111, 1'b1, 8'd26, 1'b0, 1'b1, 4'd5},  // R5
    {3'b001, 1'b0, 8'd10, 1'b0, 1'b0, 4'd7},  // R7 read
    {3'b001, 1'b1, 8'd30, 1'b0, 1'b0, 4'd7},  // R7 read
    {3'b010, 1'b0, 8'd10, 1'b0, 1'b0, 4'd7},  // R7 ctrl
    {3'b010, 1'b1, 8'd3,  1'b0, 1'b0, 4'd7},  // R7 ctrl
    {3'b100, 1'b0, 8'd1,  1'b0, 1'b1, 4'd6}   // R6 start only
  };

  task automatic chk(input int req, input logic a, input logic r,
                     input logic ea, input logic er);
    checks++;
    if (a !== ea || r !== er) begin
      errors++;
      $display("FAIL R%0d allow/reject got %b%b expected %b%b", req, a, r, ea, er);
    end
  endtask

  // One frame; restart_at > 0 inserts a second start strobe at that edge.
  task automatic frame(input logic [2:0] k, input logic o, input int n,
                       input int restart_at, input int req,
                       input logic ea, input logic er);
    @(negedge clk); cs = 1'b1; kind = k; org = o;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      start = (i == 0) || (restart_at > 0 && i == restart_at);
      edge_s = 1'b1;
      @(negedge clk); start = 1'b0; edge_s = 1'b0;
      @(negedge clk);
    end
    cs = 1'b0;
    @(negedge clk);
    chk(req, allow, reject, ea, er);
    @(negedge clk);
    chk(9, allow, reject, 1'b0, 1'b0);  // R9 single-cycle pulse
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, allow, reject, 1'b0, 1'b0);  // R1 in reset
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(1, allow, reject, 1'b0, 1'b0);  // R1 after reset

    for (int v = 0; v < NV; v++)
      frame(VEC[v][17:15], VEC[v][14], int'(VEC[v][13:6]), 0,
            int'(VEC[v][3:0]), VEC[v][5], VEC[v][4]);

    // R8: counts past saturation must not alias to a valid length
    frame(3'b100, 1'b0, 18 + 64, 0, 8, 1'b0, 1'b1);
    frame(3'b100, 1'b1, 25 + 64, 0, 8, 1'b0, 1'b1);
    frame(3'b101, 1'b1, 63, 0, 8, 1'b0, 1'b1);

    // R10: strobes with chip select low are ignored; fall without start gives nothing
    @(negedge clk); kind = 3'b100; org = 1'b0;
    for (int i = 0; i < 5; i++) begin
      start = 1'b1; edge_s = 1'b1; @(negedge clk);
      start = 1'b0; edge_s = 1'b0; @(negedge clk);
    end
    cs = 1'b1;
    for (int i = 0; i < 18; i++) begin
      edge_s = 1'b1; @(negedge clk); edge_s = 1'b0; @(negedge clk);
    end
    cs = 1'b0;
    @(negedge clk); chk(10, allow, reject, 1'b0, 1'b0);
    @(negedge clk); chk(10, allow, reject, 1'b0, 1'b0);

    // R11: restart at edge 5 of 23 leaves 18 counted since the last start
    frame(3'b100, 1'b0, 23, 5, 11, 1'b1, 1'b0);
    // R11: restart leaving 9 in word-mode erase
    frame(3'b101, 1'b1, 12, 3, 11, 1'b1, 1'b0);

    // R1: reset in mid-frame clears the count; a later fall gives nothing
    @(negedge clk); cs = 1'b1; kind = 3'b100;
    start = 1'b1; edge_s = 1'b1; @(negedge clk); start = 1'b0; edge_s = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    cs = 1'b0; @(negedge clk);
    chk(1, allow, reject, 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule